// File: doc/BRIEF.md
# Flagged Sign-Magnitude Partial-Sum Adder

This block merges two partial sums held in a three-part form: a positive flag, a negative flag and an unsigned magnitude. The pair of flags encodes the sign: positive is pos=1/neg=0, negative is pos=0/neg=1, and zero is pos=0/neg=0. A value with both flags set is not a legal input. Operand S is the more significant of the two. Whenever S is nonzero, its magnitude is at least that of T, so a difference of the two never goes below zero.

Only the four input flags decide what happens. They select one of four magnitude operations: add, subtract, pass S or pass T. The same flags produce the output sign. The output magnitude is one bit wider than the wider input, so a sum never wraps. The result can come out directly from combinational logic, or one clock later through an optional register stage. A parameter picks between the two.

Top module: `fsum_adder`

## Requirements
- R1: With both inputs positive, the output is positive (pos=1, neg=0) and its magnitude is s_mag + t_mag.
- R2: With both inputs negative, the output is negative (pos=0, neg=1) and its magnitude is s_mag + t_mag.
- R3: With both inputs nonzero and of opposite sign, the output carries the flags of S and the magnitude s_mag - t_mag. This includes equal magnitudes, which give a magnitude of 0 with the sign of S.
- R4: With T zero and S nonzero, the output equals S: the flags of S and s_mag zero-extended. The value on t_mag has no effect.
- R5: With S zero and T nonzero, the output equals T: the flags of T and t_mag zero-extended. The value on s_mag has no effect.
- R6: With both inputs zero, both output flags are 0 and the output magnitude is 0, whatever is on the magnitude inputs.
- R7: The two output flags are never both 1.
- R8: The output magnitude is max(SW,TW)+1 bits wide. The sum of two all-ones magnitudes appears in full, with no wrap.
- R9: With REG_OUT=1, a result appears on the outputs one rising clock edge after its inputs. While rst_n is low, the outputs are all zero.
- R10: With REG_OUT=0, the outputs follow the inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| s_pos | input | 1 | Positive flag of the more significant operand S |
| s_neg | input | 1 | Negative flag of S |
| s_mag | input | SW | Magnitude of S |
| t_pos | input | 1 | Positive flag of the less significant operand T |
| t_neg | input | 1 | Negative flag of T |
| t_mag | input | TW | Magnitude of T |
| o_pos | output | 1 | Positive flag of the result |
| o_neg | output | 1 | Negative flag of the result |
| o_mag | output | max(SW,TW)+1 | Magnitude of the result |

## Verification
The block holds no state other than the optional output register. A wrong operation code, or flags taken from the wrong operand, therefore shows on the outputs at once: in the same cycle for the combinational variant, and one edge later for the registered one. Most such faults show as a magnitude that is the sum where the difference was due, or the reverse. Others show as a sign taken from T instead of S, or as a stale magnitude passed through when a zero operand should have masked it. Each sign combination, the equal-magnitude difference and the all-ones sum are each driven on their own, so that one wrong decode line cannot hide behind another case.

// File: rtl/fsum_pkg.sv
package fsum_pkg;

    // Magnitude operation selected from the four input flags
    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_SUB    = 2'b01,
        OP_PASS_S = 2'b10,
        OP_PASS_T = 2'b11
    } mag_op_e;

    // Sign carried as two flags; both clear means zero
    typedef struct packed {
        logic pos;
        logic neg;
    } sign_flags_t;

endpackage

// File: rtl/fsum_flag_dec.sv
module fsum_flag_dec
    import fsum_pkg::*;
(
    input  sign_flags_t s_flags,
    input  sign_flags_t t_flags,
    output mag_op_e     op,
    output sign_flags_t out_flags,
    output logic        out_zero
);

    logic s_nz;
    logic t_nz;

    always_comb begin
        s_nz     = s_flags.pos | s_flags.neg;
        t_nz     = t_flags.pos | t_flags.neg;
        out_zero = ~s_nz & ~t_nz;
        if (!s_nz) begin
            op        = OP_PASS_T;
            out_flags = t_flags;
        end else if (!t_nz) begin
            op        = OP_PASS_S;
            out_flags = s_flags;
        end else if (s_flags.pos == t_flags.pos) begin
            op        = OP_ADD;
            out_flags = s_flags;
        end else begin
            op        = OP_SUB;
            out_flags = s_flags;
        end
    end

endmodule

// File: rtl/fsum_mag_unit.sv
module fsum_mag_unit
    import fsum_pkg::*;
#(
    parameter int SW = 8,
    parameter int TW = 8,
    parameter int OW = 9
) (
    input  mag_op_e         op,
    input  logic [SW-1:0]   s_mag,
    input  logic [TW-1:0]   t_mag,
    output logic [OW-1:0]   mag
);

    logic [OW-1:0] s_ext;
    logic [OW-1:0] t_ext;

    always_comb begin
        s_ext = OW'(s_mag);
        t_ext = OW'(t_mag);
        unique case (op)
            OP_ADD:    mag = s_ext + t_ext;
            OP_SUB:    mag = s_ext - t_ext;
            OP_PASS_S: mag = s_ext;
            default:   mag = t_ext;
        endcase
    end

endmodule

// File: rtl/fsum_adder.sv
module fsum_adder
    import fsum_pkg::*;
#(
    parameter int SW      = 8,
    parameter int TW      = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int MW     = (SW > TW) ? SW : TW,
    localparam int OW     = MW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_pos,
    input  logic          s_neg,
    input  logic [SW-1:0] s_mag,
    input  logic          t_pos,
    input  logic          t_neg,
    input  logic [TW-1:0] t_mag,
    output logic          o_pos,
    output logic          o_neg,
    output logic [OW-1:0] o_mag
);

    typedef struct packed {
        logic          pos;
        logic          neg;
        logic [OW-1:0] mag;
    } result_t;

    sign_flags_t   s_flags;
    sign_flags_t   t_flags;
    sign_flags_t   sel_flags;
    mag_op_e       sel_op;
    logic          sel_zero;
    logic [OW-1:0] raw_mag;
    result_t       res_d;
    result_t       res_out;

    assign s_flags = '{pos: s_pos, neg: s_neg};
    assign t_flags = '{pos: t_pos, neg: t_neg};

    fsum_flag_dec u_dec (
        .s_flags   (s_flags),
        .t_flags   (t_flags),
        .op        (sel_op),
        .out_flags (sel_flags),
        .out_zero  (sel_zero)
    );

    fsum_mag_unit #(
        .SW (SW),
        .TW (TW),
        .OW (OW)
    ) u_mag (
        .op    (sel_op),
        .s_mag (s_mag),
        .t_mag (t_mag),
        .mag   (raw_mag)
    );

    // Next-value computation
    always_comb begin
        res_d.pos = sel_flags.pos;
        res_d.neg = sel_flags.neg;
        res_d.mag = sel_zero ? '0 : raw_mag;
    end

    generate
        if (REG_OUT) begin : g_reg
            result_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
            assign res_out = res_q;
        end else begin : g_comb
            assign res_out = res_d;
        end
    endgenerate

    assign o_pos = res_out.pos;
    assign o_neg = res_out.neg;
    assign o_mag = res_out.mag;

endmodule

// File: rtl/fsum_adder_chk.sv
module fsum_adder_chk #(
    parameter int SW      = 8,
    parameter int TW      = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int MW     = (SW > TW) ? SW : TW,
    localparam int OW     = MW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_pos,
    input logic          s_neg,
    input logic [SW-1:0] s_mag,
    input logic          t_pos,
    input logic          t_neg,
    input logic [TW-1:0] t_mag,
    input logic          o_pos,
    input logic          o_neg,
    input logic [OW-1:0] o_mag
);

    // Inputs aligned with the cycle in which their result is visible
    logic          c_sp, c_sn, c_tp, c_tn;
    logic [SW-1:0] c_sm;
    logic [TW-1:0] c_tm;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    c_sp <= 1'b0; c_sn <= 1'b0; c_sm <= '0;
                    c_tp <= 1'b0; c_tn <= 1'b0; c_tm <= '0;
                end else begin
                    c_sp <= s_pos; c_sn <= s_neg; c_sm <= s_mag;
                    c_tp <= t_pos; c_tn <= t_neg; c_tm <= t_mag;
                end
            end
        end else begin : g_now
            assign c_sp = s_pos; assign c_sn = s_neg; assign c_sm = s_mag;
            assign c_tp = t_pos; assign c_tn = t_neg; assign c_tm = t_mag;
        end
    endgenerate

    logic [OW-1:0] c_sum;
    logic [OW-1:0] c_diff;
    logic          c_s_nz;
    logic          c_t_nz;
    assign c_sum  = OW'(c_sm) + OW'(c_tm);
    assign c_diff = OW'(c_sm) - OW'(c_tm);
    assign c_s_nz = c_sp | c_sn;
    assign c_t_nz = c_tp | c_tn;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_pos, o_neg})); // R7

    AST_ADD_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sp && c_tp) |-> (o_pos && !o_neg && o_mag == c_sum)); // R1

    AST_ADD_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sn && c_tn) |-> (o_neg && !o_pos && o_mag == c_sum)); // R2

    AST_MIXED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_sp && c_tn) || (c_sn && c_tp)) |->
        (o_pos == c_sp && o_neg == c_sn && o_mag == c_diff)); // R3

    AST_PASS_S: assert property (@(posedge clk) disable iff (!rst_n)
        (c_s_nz && !c_t_nz) |->
        (o_pos == c_sp && o_neg == c_sn && o_mag == OW'(c_sm))); // R4

    AST_PASS_T: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_s_nz && c_t_nz) |->
        (o_pos == c_tp && o_neg == c_tn && o_mag == OW'(c_tm))); // R5

    AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_s_nz && !c_t_nz) |-> (!o_pos && !o_neg && o_mag == '0)); // R6

endmodule

bind fsum_adder fsum_adder_chk #(
    .SW      (SW),
    .TW      (TW),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .s_pos (s_pos),
    .s_neg (s_neg),
    .s_mag (s_mag),
    .t_pos (t_pos),
    .t_neg (t_neg),
    .t_mag (t_mag),
    .o_pos (o_pos),
    .o_neg (o_neg),
    .o_mag (o_mag)
);

// File: tb/tb_fsum_adder.sv
module tb_fsum_adder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_pos = 1'b0, s_neg = 1'b0, t_pos = 1'b0, t_neg = 1'b0;
    logic [7:0] s_mag = '0, t_mag = '0;
    logic       r_pos, r_neg, c_pos, c_neg;
    logic [8:0] r_mag, c_mag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fsum_adder #(.SW(8), .TW(8), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_pos(s_pos), .s_neg(s_neg), .s_mag(s_mag),
        .t_pos(t_pos), .t_neg(t_neg), .t_mag(t_mag),
        .o_pos(r_pos), .o_neg(r_neg), .o_mag(r_mag)
    );

    fsum_adder #(.SW(8), .TW(8), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n),
        .s_pos(s_pos), .s_neg(s_neg), .s_mag(s_mag),
        .t_pos(t_pos), .t_neg(t_neg), .t_mag(t_mag),
        .o_pos(c_pos), .o_neg(c_neg), .o_mag(c_mag)
    );

    typedef struct packed {
        logic       sp;
        logic       sn;
        logic [7:0] sm;
        logic       tp;
        logic       tn;
        logic [7:0] tm;
        logic       ep;
        logic       en;
        logic [8:0] em;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'd100, 1'b1, 1'b0, 8'd50,  1'b1, 1'b0, 9'd150, 4'd1}, // R1
        '{1'b0, 1'b1, 8'd30,  1'b0, 1'b1, 8'd12,  1'b0, 1'b1, 9'd42,  4'd2}, // R2
        '{1'b1, 1'b0, 8'd200, 1'b0, 1'b1, 8'd55,  1'b1, 1'b0, 9'd145, 4'd3}, // R3
        '{1'b0, 1'b1, 8'd90,  1'b1, 1'b0, 8'd90,  1'b0, 1'b1, 9'd0,   4'd3}, // R3 equal
        '{1'b1, 1'b0, 8'd1,   1'b0, 1'b1, 8'd1,   1'b1, 1'b0, 9'd0,   4'd3}, // R3 equal
        '{1'b0, 1'b1, 8'd77,  1'b0, 1'b0, 8'd33,  1'b0, 1'b1, 9'd77,  4'd4}, // R4
        '{1'b1, 1'b0, 8'd5,   1'b0, 1'b0, 8'd200, 1'b1, 1'b0, 9'd5,   4'd4}, // R4
        '{1'b0, 1'b0, 8'd99,  1'b0, 1'b1, 8'd40,  1'b0, 1'b1, 9'd40,  4'd5}, // R5
        '{1'b0, 1'b0, 8'd0,   1'b1, 1'b0, 8'd255, 1'b1, 1'b0, 9'd255, 4'd5}, // R5
        '{1'b0, 1'b0, 8'd12,  1'b0, 1'b0, 8'd34,  1'b0, 1'b0, 9'd0,   4'd6}, // R6
        '{1'b1, 1'b0, 8'd255, 1'b1, 1'b0, 8'd255, 1'b1, 1'b0, 9'd510, 4'd8}, // R8
        '{1'b0, 1'b1, 8'd255, 1'b0, 1'b1, 8'd1,   1'b0, 1'b1, 9'd256, 4'd8}  // R8
    };

    task automatic check(input bit ok, input string req, input logic [10:0] act,
                         input logic [10:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got pos=%b neg=%b mag=%0d, expected pos=%b neg=%b mag=%0d",
                     req, act[10], act[9], act[8:0], exp[10], exp[9], exp[8:0]);
        end
    endtask

    task automatic drive(input vec_t v);
        s_pos = v.sp; s_neg = v.sn; s_mag = v.sm;
        t_pos = v.tp; t_neg = v.tn; t_mag = v.tm;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [10:0] exp;
        logic [10:0] prev;
        // R9: reset holds outputs at zero despite nonzero inputs
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check({r_pos, r_neg, r_mag} == 11'd0, "R9 reset", {r_pos, r_neg, r_mag}, 11'd0);
        rst_n = 1'b1;

        // Vector table: comb instance in-cycle (R10), registered one edge later (R9)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            exp = {VECS[i].ep, VECS[i].en, VECS[i].em};
            #1;
            check({c_pos, c_neg, c_mag} == exp, $sformatf("R%0d comb vec %0d (R10)", VECS[i].req, i),
                  {c_pos, c_neg, c_mag}, exp);
            check(!(c_pos && c_neg), "R7 comb flags", {c_pos, c_neg, c_mag}, exp);
            @(negedge clk);
            check({r_pos, r_neg, r_mag} == exp, $sformatf("R%0d reg vec %0d", VECS[i].req, i),
                  {r_pos, r_neg, r_mag}, exp);
        end

        // R9: registered output holds the old result until the next edge
        @(negedge clk);
        prev = {r_pos, r_neg, r_mag};
        drive(VECS[1]);
        #1;
        check({r_pos, r_neg, r_mag} == prev, "R9 latency hold", {r_pos, r_neg, r_mag}, prev);
        @(negedge clk);
        exp = {1'b0, 1'b1, 9'd42};
        check({r_pos, r_neg, r_mag} == exp, "R9 latency update", {r_pos, r_neg, r_mag}, exp);

        // R6: zero operands with changing magnitudes stay at zero
        @(negedge clk);
        s_pos = 0; s_neg = 0; s_mag = 8'hFF; t_pos = 0; t_neg = 0; t_mag = 8'hAA;
        #1;
        check({c_pos, c_neg, c_mag} == 11'd0, "R6 comb zero", {c_pos, c_neg, c_mag}, 11'd0);
        @(negedge clk);
        check({r_pos, r_neg, r_mag} == 11'd0, "R6 reg zero", {r_pos, r_neg, r_mag}, 11'd0);

        // R9: asynchronous reset mid-run clears the registered output
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check({r_pos, r_neg, r_mag} == 11'd0, "R9 async reset", {r_pos, r_neg, r_mag}, 11'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp = {1'b1, 1'b0, 9'd150};
        check({r_pos, r_neg, r_mag} == exp, "R1 after reset", {r_pos, r_neg, r_mag}, exp);

        finish_run();
    end

endmodule